// File: doc/BRIEF.md
# Exception Entry Vector Unit

This unit performs the entry step of exception handling for a 32-bit core. Each cycle it may take one request, which carries an exception class, an exception code, the PC of the faulting instruction, a flag that says whether that instruction sits in a branch delay slot, and a snapshot of the relevant status and configuration bits. One cycle later it presents the handler address and a set of write strobes and values for the control registers: the saved PC for general exceptions, for error-level entries and for debug entries, the delay-slot bit and the code field of the cause register, and the exception-level, error-level, boot-vector and NMI status bits.

A general exception goes to a base plus an offset. The base is a fixed boot location when the boot-vector bit is set, and the software-programmed exception base with its low 10 bits cleared when it is not. The offset depends on the exception code, the TLB refill flag, the exception-level bit, the interrupt-vector bit and, in vectored interrupt mode, a priority encoder over the enabled pending interrupt lines scaled by a programmable spacing. NMI, soft reset and the debug classes go to fixed addresses.

Request classes on `req_class` are: 0 general, 1 NMI, 2 soft reset, 3 debug (corrected), 4 debug single step. The unit emits a delay-flag clear strobe on every entry so the pipeline can drop its branch-delay state.

Top module: `exu_entry`

## Requirements
- R1: While `rst_n` is low, `done` and every write strobe and status-set output read 0 after the next clock edge, whatever the request inputs are.
- R2: A request sampled with `req_valid` high at a clock edge gives `done` high for exactly the following cycle with its results. A cycle with `req_valid` low gives `done` low and all other outputs at 0 in the following cycle. Back-to-back requests each get their own result.
- R3: For a general exception (class 0) the handler base is 0xBFC00200 when `st_bev` is 1, and otherwise `ebase` with bits 9:0 forced to zero. The offset is 0x180 unless R4, R5 or R6 chooses another.
- R4: For code 0 (interrupt) with `st_vint` low, the offset is 0x200 when `st_iv` is 1 and 0x180 when it is 0.
- R5: For code 0 with `st_vint` high, the offset is 0x200 + v × (`st_spacing` × 32). v is the index of the highest set bit, searched from 7 down to 1, of `irq_pending & irq_mask`. v is 0 when none of bits 7..1 is set. Bit 0 never selects a vector.
- R6: For code 2 (TLB load) or 3 (TLB store) with `req_refill` 1 and `st_exl` 0, the offset is 0x000. With `st_exl` 1 or `req_refill` 0, the offset is 0x180.
- R7: A general exception asserts `cause_we` and puts `req_code` on `exc_code`. This is the 5-bit field that is written to cause bits 6:2. The codes are 0 interrupt, 1 modified, 2 TLB load, 3 TLB store, 4 and 5 address error load and store, 6 and 7 instruction and data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap. Other classes leave `cause_we` at 0.
- R8: A general exception with `st_exl` 0 asserts `epc_we`, `bd_we` and `set_exl`. `resume_pc` is `req_pc − 4` with `bd_val` 1 when `req_dslot` is 1, and `req_pc` with `bd_val` 0 otherwise.
- R9: A general exception with `st_exl` 1 leaves `epc_we`, `bd_we` and `set_exl` at 0.
- R10: NMI and soft reset assert `errorepc_we`, `set_erl` and `set_bev`, jump to 0xBFC00000, and put the delay-slot-corrected PC on `resume_pc`. `set_nmi` is 1 for NMI only.
- R11: Both debug classes assert `depc_we` and `enter_debug` and jump to 0xBFC00480. Class 3 puts the delay-slot-corrected PC on `resume_pc`. Class 4 (single step) puts `req_pc` on it unchanged.
- R12: For classes 1 to 4, `bd_we` is 1 with `bd_val` 0 when `st_exl` is 0, and `bd_we` is 0 when `st_exl` is 1.
- R13: `dslot_clr` is 1 in every cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request this cycle |
| req_class | input | 3 | 0 general, 1 NMI, 2 soft reset, 3 debug, 4 single step |
| req_code | input | 5 | Exception code for a general exception |
| req_pc | input | 32 | PC of the faulting instruction |
| req_dslot | input | 1 | Faulting instruction is in a branch delay slot |
| req_refill | input | 1 | TLB miss found no matching entry (refill case) |
| st_exl | input | 1 | Exception level currently set |
| st_bev | input | 1 | Boot exception vectors selected |
| st_iv | input | 1 | Interrupts use the dedicated interrupt offset |
| st_vint | input | 1 | Vectored interrupt mode enabled |
| st_spacing | input | 6 | Vector spacing field, in units of 32 bytes |
| irq_pending | input | 8 | Pending interrupt lines |
| irq_mask | input | 8 | Interrupt mask bits |
| ebase | input | 32 | Programmed exception base |
| done | output | 1 | Entry results valid this cycle |
| new_pc | output | 32 | Handler address |
| resume_pc | output | 32 | Value for the selected saved-PC register |
| epc_we | output | 1 | Write general saved PC |
| errorepc_we | output | 1 | Write error saved PC |
| depc_we | output | 1 | Write debug saved PC |
| cause_we | output | 1 | Write cause code field |
| exc_code | output | 5 | Cause code field value |
| bd_we | output | 1 | Write cause delay-slot bit |
| bd_val | output | 1 | Cause delay-slot bit value |
| set_exl | output | 1 | Set exception level |
| set_erl | output | 1 | Set error level |
| set_bev | output | 1 | Set boot-vector bit |
| set_nmi | output | 1 | Set NMI status bit |
| enter_debug | output | 1 | Enter debug mode |
| dslot_clr | output | 1 | Clear the pipeline branch-delay flag |

## Verification
The assertions assume that `req_class` stays within the five defined values. They compare each registered result with the request inputs of the previous cycle, so they also assume that nothing but the clock edge separates request and result. The bench applies only classes 0 to 4 and general codes 0 to 13. It drives all inputs at the falling edge and holds them for one full cycle. It sweeps every pending-line pattern against several masks and spacings, and it crosses every code with the exception-level, boot-vector, delay-slot and refill bits, including inputs that change in consecutive cycles.

// File: rtl/exu_pkg.sv
// Shared constants and types for the exception entry unit.
// Assumes a 32-bit address space and the fixed boot and debug vectors below.
package exu_pkg;

    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        CLS_GENERAL = 3'd0,
        CLS_NMI     = 3'd1,
        CLS_SOFTRST = 3'd2,
        CLS_DEBUG   = 3'd3,
        CLS_STEP    = 3'd4
    } exc_class_e;

    localparam logic [XLEN-1:0] VEC_BOOT_GENERAL = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] VEC_ERROR_ENTRY  = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] VEC_DEBUG_ENTRY  = 32'hBFC0_0480;
    localparam logic [XLEN-1:0] BASE_LOW_MASK    = 32'h0000_03FF;

    localparam logic [XLEN-1:0] OFF_DEFAULT = 32'h180;
    localparam logic [XLEN-1:0] OFF_IRQ     = 32'h200;
    localparam logic [XLEN-1:0] OFF_REFILL  = 32'h000;

    localparam logic [4:0] CODE_IRQ       = 5'd0;
    localparam logic [4:0] CODE_TLB_LOAD  = 5'd2;
    localparam logic [4:0] CODE_TLB_STORE = 5'd3;

    // One registered entry result.
    typedef struct packed {
        logic [XLEN-1:0] new_pc;
        logic [XLEN-1:0] resume_pc;
        logic            epc_we;
        logic            errorepc_we;
        logic            depc_we;
        logic            cause_we;
        logic [4:0]      exc_code;
        logic            bd_we;
        logic            bd_val;
        logic            set_exl;
        logic            set_erl;
        logic            set_bev;
        logic            set_nmi;
        logic            enter_debug;
        logic            dslot_clr;
        logic            done;
    } entry_t;

endpackage

// File: rtl/exu_irq_prio.sv
// Priority encoder over masked interrupt lines.
// Returns the highest armed line index; line 0 never wins, so an idle
// or line-0-only pattern yields vector 0.
module exu_irq_prio #(
    parameter int LINES = 8,
    localparam int VEC_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] pending,
    input  logic [LINES-1:0] mask,
    output logic [VEC_W-1:0] vec
);

    logic [LINES-1:0] armed;

    // Gate each pending line with its mask bit.
    for (genvar g = 0; g < LINES; g++) begin : g_arm
        assign armed[g] = pending[g] & mask[g];
    end

    // Scan upward so the highest armed line is the last one kept.
    always_comb begin
        vec = '0;
        for (int i = 0; i < LINES; i++) begin
            if (armed[i]) begin
                vec = (i == 0) ? '0 : VEC_W'(i);
            end
        end
    end

endmodule

// File: rtl/exu_vector_calc.sv
// Handler address for general exceptions: base selection plus offset
// from code, refill flag, exception level and interrupt mode.
// Assumes the vector index is already prioritised by the caller.
module exu_vector_calc #(
    parameter int LINES     = 8,
    parameter int SPACING_W = 6,
    localparam int VEC_W    = $clog2(LINES),
    localparam int STEP_W   = SPACING_W + 5
) (
    input  logic [4:0]              code,
    input  logic                    exl,
    input  logic                    bev,
    input  logic                    iv,
    input  logic                    vint_en,
    input  logic                    refill,
    input  logic [SPACING_W-1:0]    spacing,
    input  logic [VEC_W-1:0]        vec,
    input  logic [exu_pkg::XLEN-1:0] ebase,
    output logic [exu_pkg::XLEN-1:0] target
);
    import exu_pkg::*;

    logic [XLEN-1:0]   base;
    logic [XLEN-1:0]   offset;
    logic [STEP_W-1:0] step;

    // Spacing field counts 32-byte units.
    assign step = {spacing, 5'b0_0000};

    // Base: boot location or programmed base aligned to 1 KiB.
    assign base = bev ? VEC_BOOT_GENERAL : (ebase & ~BASE_LOW_MASK);

    // Offset selection by code and mode.
    always_comb begin
        offset = OFF_DEFAULT;
        if (code == CODE_IRQ) begin
            if (vint_en) begin
                offset = OFF_IRQ + (XLEN'(vec) * XLEN'(step));
            end else if (iv) begin
                offset = OFF_IRQ;
            end
        end else if ((code == CODE_TLB_LOAD || code == CODE_TLB_STORE)
                     && refill && !exl) begin
            offset = OFF_REFILL;
        end
    end

    // Final handler address.
    assign target = base + offset;

endmodule

// File: rtl/exu_resume_calc.sv
// Return-address correction: back up one instruction when the fault is
// in a delay slot, unless the caller asks for the raw PC.
module exu_resume_calc #(
    parameter int INSN_BYTES = 4
) (
    input  logic [exu_pkg::XLEN-1:0] pc,
    input  logic                     dslot,
    input  logic                     raw,
    output logic [exu_pkg::XLEN-1:0] resume
);
    import exu_pkg::*;

    // Select the branch address or the faulting PC.
    assign resume = (dslot && !raw) ? (pc - XLEN'(INSN_BYTES)) : pc;

endmodule

// File: rtl/exu_entry.sv
// Exception entry unit top. Accepts one request per cycle and registers
// the handler address and all control-register write strobes, which are
// valid for one cycle with done. Assumes req_class is one of 0..4.
module exu_entry #(
    parameter int IRQ_LINES  = 8,
    parameter int SPACING_W  = 6,
    parameter int INSN_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_class,
    input  logic [4:0]           req_code,
    input  logic [31:0]          req_pc,
    input  logic                 req_dslot,
    input  logic                 req_refill,
    input  logic                 st_exl,
    input  logic                 st_bev,
    input  logic                 st_iv,
    input  logic                 st_vint,
    input  logic [SPACING_W-1:0] st_spacing,
    input  logic [IRQ_LINES-1:0] irq_pending,
    input  logic [IRQ_LINES-1:0] irq_mask,
    input  logic [31:0]          ebase,
    output logic                 done,
    output logic [31:0]          new_pc,
    output logic [31:0]          resume_pc,
    output logic                 epc_we,
    output logic                 errorepc_we,
    output logic                 depc_we,
    output logic                 cause_we,
    output logic [4:0]           exc_code,
    output logic                 bd_we,
    output logic                 bd_val,
    output logic                 set_exl,
    output logic                 set_erl,
    output logic                 set_bev,
    output logic                 set_nmi,
    output logic                 enter_debug,
    output logic                 dslot_clr
);
    import exu_pkg::*;

    localparam int VEC_W = $clog2(IRQ_LINES);

    exc_class_e      cls;
    logic [VEC_W-1:0] irq_vec;
    logic [XLEN-1:0]  gen_target;
    logic [XLEN-1:0]  resume_val;
    entry_t           nx;
    entry_t           q;

    assign cls = exc_class_e'(req_class);

    exu_irq_prio #(
        .LINES (IRQ_LINES)
    ) u_prio (
        .pending (irq_pending),
        .mask    (irq_mask),
        .vec     (irq_vec)
    );

    exu_vector_calc #(
        .LINES     (IRQ_LINES),
        .SPACING_W (SPACING_W)
    ) u_vec (
        .code    (req_code),
        .exl     (st_exl),
        .bev     (st_bev),
        .iv      (st_iv),
        .vint_en (st_vint),
        .refill  (req_refill),
        .spacing (st_spacing),
        .vec     (irq_vec),
        .ebase   (ebase),
        .target  (gen_target)
    );

    exu_resume_calc #(
        .INSN_BYTES (INSN_BYTES)
    ) u_resume (
        .pc     (req_pc),
        .dslot  (req_dslot),
        .raw    (cls == CLS_STEP),
        .resume (resume_val)
    );

    // Build the entry record for the current request by class.
    always_comb begin
        nx           = '0;
        nx.done      = 1'b1;
        nx.dslot_clr = 1'b1;
        nx.resume_pc = resume_val;
        unique case (cls)
            CLS_NMI, CLS_SOFTRST: begin
                nx.new_pc      = VEC_ERROR_ENTRY;
                nx.errorepc_we = 1'b1;
                nx.set_erl     = 1'b1;
                nx.set_bev     = 1'b1;
                nx.set_nmi     = (cls == CLS_NMI);
                nx.bd_we       = !st_exl;
            end
            CLS_DEBUG, CLS_STEP: begin
                nx.new_pc      = VEC_DEBUG_ENTRY;
                nx.depc_we     = 1'b1;
                nx.enter_debug = 1'b1;
                nx.bd_we       = !st_exl;
            end
            default: begin
                nx.new_pc   = gen_target;
                nx.cause_we = 1'b1;
                nx.exc_code = req_code;
                if (!st_exl) begin
                    nx.epc_we  = 1'b1;
                    nx.bd_we   = 1'b1;
                    nx.bd_val  = req_dslot;
                    nx.set_exl = 1'b1;
                end
            end
        endcase
    end

    // Register the record; idle cycles and reset clear every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (req_valid) begin
            q <= nx;
        end else begin
            q <= '0;
        end
    end

    assign done        = q.done;
    assign new_pc      = q.new_pc;
    assign resume_pc   = q.resume_pc;
    assign epc_we      = q.epc_we;
    assign errorepc_we = q.errorepc_we;
    assign depc_we     = q.depc_we;
    assign cause_we    = q.cause_we;
    assign exc_code    = q.exc_code;
    assign bd_we       = q.bd_we;
    assign bd_val      = q.bd_val;
    assign set_exl     = q.set_exl;
    assign set_erl     = q.set_erl;
    assign set_bev     = q.set_bev;
    assign set_nmi     = q.set_nmi;
    assign enter_debug = q.enter_debug;
    assign dslot_clr   = q.dslot_clr;

endmodule

// File: rtl/exu_entry_chk.sv
// Checker for the exception entry unit, attached by bind.
// Assumes req_class is one of the five defined classes.
module exu_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  req_class,
    input logic [31:0] req_pc,
    input logic        req_dslot,
    input logic        st_exl,
    input logic        done,
    input logic [31:0] new_pc,
    input logic [31:0] resume_pc,
    input logic        epc_we,
    input logic        errorepc_we,
    input logic        depc_we,
    input logic        bd_we,
    input logic        bd_val,
    input logic        set_exl,
    input logic        set_erl,
    input logic        set_bev,
    input logic        enter_debug,
    input logic        dslot_clr
);

    p_done_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done && !epc_we && !errorepc_we && !depc_we && !set_exl);

    p_one_save_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({epc_we, errorepc_we, depc_we}));

    // class 0 is general
    p_exl_holds_epc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_class == 3'd0 && st_exl |=> !epc_we && !bd_we && !set_exl);

    p_dslot_epc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_class == 3'd0 && !st_exl && req_dslot
        |=> epc_we && bd_val && resume_pc == $past(req_pc) - 32'd4);

    p_error_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        errorepc_we |-> new_pc == 32'hBFC0_0000 && set_erl && set_bev);

    p_debug_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
        depc_we |-> new_pc == 32'hBFC0_0480 && enter_debug);

    p_delay_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dslot_clr);

endmodule

bind exu_entry exu_entry_chk u_chk (.*);

// File: tb/exu_entry_tb.sv
// Sweep bench for exu_entry with an arithmetic reference model.
module exu_entry_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_class = '0;
    logic [4:0]  req_code = '0;
    logic [31:0] req_pc = '0;
    logic        req_dslot = 1'b0;
    logic        req_refill = 1'b0;
    logic        st_exl = 1'b0;
    logic        st_bev = 1'b0;
    logic        st_iv = 1'b0;
    logic        st_vint = 1'b0;
    logic [5:0]  st_spacing = '0;
    logic [7:0]  irq_pending = '0;
    logic [7:0]  irq_mask = '0;
    logic [31:0] ebase = '0;

    logic        done, epc_we, errorepc_we, depc_we, cause_we;
    logic [31:0] new_pc, resume_pc;
    logic [4:0]  exc_code;
    logic        bd_we, bd_val, set_exl, set_erl, set_bev, set_nmi, enter_debug, dslot_clr;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    exu_entry u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
        .req_code(req_code), .req_pc(req_pc), .req_dslot(req_dslot),
        .req_refill(req_refill), .st_exl(st_exl), .st_bev(st_bev), .st_iv(st_iv),
        .st_vint(st_vint), .st_spacing(st_spacing), .irq_pending(irq_pending),
        .irq_mask(irq_mask), .ebase(ebase), .done(done), .new_pc(new_pc),
        .resume_pc(resume_pc), .epc_we(epc_we), .errorepc_we(errorepc_we),
        .depc_we(depc_we), .cause_we(cause_we), .exc_code(exc_code), .bd_we(bd_we),
        .bd_val(bd_val), .set_exl(set_exl), .set_erl(set_erl), .set_bev(set_bev),
        .set_nmi(set_nmi), .enter_debug(enter_debug), .dslot_clr(dslot_clr)
    );

    function automatic logic [81:0] observed();
        return {new_pc, resume_pc, epc_we, errorepc_we, depc_we, cause_we, exc_code,
                bd_we, bd_val, set_exl, set_erl, set_bev, set_nmi, enter_debug,
                dslot_clr, done};
    endfunction

    // Reference result for the request currently on the inputs.
    function automatic logic [81:0] expect_now();
        logic [31:0] tgt, res, base, off;
        logic e_epc, e_err, e_dbg, e_cause, e_bdwe, e_bdv, e_exl, e_erl, e_bev, e_nmi, e_dm;
        logic [4:0] code;
        logic [7:0] armed;
        int v;
        {e_epc, e_err, e_dbg, e_cause, e_bdwe, e_bdv, e_exl, e_erl, e_bev, e_nmi, e_dm} = '0;
        code = 5'd0;
        res = (req_dslot && req_class != 3'd4) ? req_pc - 32'd4 : req_pc;
        if (req_class == 3'd1 || req_class == 3'd2) begin
            tgt = 32'hBFC0_0000; e_err = 1; e_erl = 1; e_bev = 1;
            e_nmi = (req_class == 3'd1); e_bdwe = !st_exl;
        end else if (req_class == 3'd3 || req_class == 3'd4) begin
            tgt = 32'hBFC0_0480; e_dbg = 1; e_dm = 1; e_bdwe = !st_exl;
        end else begin
            base = st_bev ? 32'hBFC0_0200 : {ebase[31:10], 10'd0};
            off = 32'h180;
            if (req_code == 5'd0) begin
                if (st_vint) begin
                    armed = irq_pending & irq_mask;
                    v = 0;
                    for (int i = 1; i < 8; i++) if (armed[i]) v = i;
                    off = 32'h200 + 32'(v) * (32'(st_spacing) * 32);
                end else if (st_iv) begin
                    off = 32'h200;
                end
            end else if ((req_code == 5'd2 || req_code == 5'd3) && req_refill && !st_exl) begin
                off = 32'h0;
            end
            tgt = base + off;
            e_cause = 1; code = req_code;
            if (!st_exl) begin
                e_epc = 1; e_bdwe = 1; e_bdv = req_dslot; e_exl = 1;
            end
        end
        return {tgt, res, e_epc, e_err, e_dbg, e_cause, code, e_bdwe, e_bdv, e_exl,
                e_erl, e_bev, e_nmi, e_dm, 1'b1, 1'b1};
    endfunction

    task automatic check(input logic [81:0] exp, input string tag);
        logic [81:0] act;
        act = observed();
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request, check its result, then check the idle cycle after.
    task automatic run(input logic [2:0] cls, input logic [4:0] code, input logic [31:0] pc,
                       input logic ds, input logic refill, input logic exl, input logic bev,
                       input logic iv, input logic vint, input logic [5:0] sp,
                       input logic [7:0] pend, input logic [7:0] msk, input logic [31:0] eb,
                       input string tag);
        logic [81:0] exp;
        @(negedge clk);
        req_class = cls; req_code = code; req_pc = pc; req_dslot = ds; req_refill = refill;
        st_exl = exl; st_bev = bev; st_iv = iv; st_vint = vint; st_spacing = sp;
        irq_pending = pend; irq_mask = msk; ebase = eb; req_valid = 1'b1;
        exp = expect_now();
        @(negedge clk);
        req_valid = 1'b0;
        check(exp, tag);
        @(negedge clk);
        check(82'd0, "R2 idle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [81:0] exp_a, exp_b;
        string tag;
        // R1: reset with a request held on the inputs
        req_valid = 1'b1; req_class = 3'd1;
        repeat (3) @(negedge clk);
        check(82'd0, "R1 reset");
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(82'd0, "R1 after release");

        // General codes crossed with exl, delay slot, bev, refill (R3 R6 R7 R8 R9 R13)
        for (int c = 1; c < 14; c++)
            for (int m = 0; m < 16; m++) begin
                if (m[2]) tag = "R9";
                else if ((c == 2 || c == 3) && m[3]) tag = "R6";
                else if (m[1]) tag = "R3";
                else if (m[0]) tag = "R8";
                else tag = "R7 R13";
                run(3'd0, 5'(c), 32'h8000_1000 + 32'(c) * 64, m[0], m[3], m[2], m[1],
                    1'b0, 1'b0, 6'd0, 8'h00, 8'h00,
                    32'h8000_0000 | (32'(c) << 12) | 32'h2AB, tag);
            end

        // Non-vectored interrupts (R4)
        for (int m = 0; m < 16; m++)
            run(3'd0, 5'd0, 32'h0040_0100, m[0], 1'b0, m[2], m[1], m[3], 1'b0, 6'd9,
                8'hFF, 8'hFF, 32'h9000_07FF, "R4");

        // Vectored interrupts: all pending patterns, several masks and spacings (R5)
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 3; k++)
                for (int p = 0; p < 256; p++)
                    run(3'd0, 5'd0, 32'h0040_2000 + 32'(p) * 4, p[0], 1'b0, 1'b0, s[0],
                        1'b1, 1'b1, (s == 0) ? 6'd0 : (s == 1) ? 6'd1 : (s == 2) ? 6'd5 : 6'd63,
                        8'(p), (k == 0) ? 8'hFF : (k == 1) ? 8'h0F : 8'hA5,
                        32'hA000_0000, "R5");

        // NMI, soft reset, debug, single step (R10 R11 R12)
        for (int cl = 1; cl < 5; cl++)
            for (int m = 0; m < 8; m++)
                run(3'(cl), 5'd7, 32'h1234_5678 + 32'(m) * 16, m[0], 1'b1, m[1], m[2],
                    1'b1, 1'b1, 6'd3, 8'hF0, 8'hF0, 32'h8000_0000,
                    (cl < 3) ? "R10 R12" : "R11 R12");

        // Back-to-back requests (R2)
        @(negedge clk);
        req_class = 3'd0; req_code = 5'd12; req_pc = 32'h0000_4000; req_dslot = 1'b1;
        st_exl = 1'b0; st_bev = 1'b0; st_vint = 1'b0; ebase = 32'h8000_1000;
        req_valid = 1'b1;
        exp_a = expect_now();
        @(negedge clk);
        check(exp_a, "R2 first of pair");
        req_class = 3'd4; req_pc = 32'h0000_5000; st_exl = 1'b1;
        exp_b = expect_now();
        @(negedge clk);
        req_valid = 1'b0;
        check(exp_b, "R2 second of pair");
        @(negedge clk);
        check(82'd0, "R2 idle after pair");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule